// File: doc/BRIEF.md
# Conversion Result Hand-off with Read Protection

This block stands between a converter's result pipeline and the serial port that reads results out. Each finished conversion word is placed in an output word register, and an active-low ready flag tells the host that a fresh word is waiting. While the serial port is shifting a word out, that word is frozen. A result that finishes during the read goes into a one-word holding buffer. When the read ends, the buffered word moves into the output register.

The flag goes high when a read completes. It does not fall again until a programmable number of clock cycles has passed, so the host always sees a clean high pulse between two words. The result input has no back-pressure. A valid strobe is accepted in every cycle. During a read the newest arrival replaces whatever the buffer held, so only the most recent result is kept. The read-start and read-complete indications are single-cycle pulses from the serial port.

Top module: `result_handoff`

## Requirements
- R1: When a result is loaded into the output word while the flag is high and its high-time window has expired, the flag falls on the same clock edge that updates `out_word`.
- R2: `rdy_n` rises only on the edge where `rd_done` closes an active read. A `rd_done` pulse with no read active is ignored.
- R3: While a read is active (from the `rd_start` edge up to and including the cycle before `rd_done`), `out_word` and the flag level do not change when results arrive.
- R4: The holding buffer stores one word. A later arrival during the same read replaces the earlier one, and a discarded word is never delivered afterwards.
- R5: On the `rd_done` edge the buffered word is copied into `out_word` if the buffer is full. If a result arrives in that same cycle, that result goes to `out_word` instead, and the buffer is emptied in either case.
- R6: After a read completes with a new word delivered, `rdy_n` stays high for exactly `MIN_HIGH` cycles and then falls. A result arriving inside that window updates `out_word` at once, but the flag still waits for the window to end.
- R7: When no read is active and the flag is low, an arriving result overwrites `out_word` on the next edge and the flag stays low.
- R8: A read that completes with no new word available leaves `rdy_n` high, with `out_word` unchanged, until a new result arrives.
- R9: While `rst_n` is low, `rdy_n` is 1 and `out_word` is 0. The buffer is empty and no read is active.
- R10: A result that arrives in the same cycle as `rd_start` counts as arriving during the read, so it is buffered rather than written to `out_word`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| res_valid | input | 1 | Result strobe; always accepted, no back-pressure |
| res_data | input | 24 | Result word, qualified by `res_valid` |
| rd_start | input | 1 | One-cycle pulse: serial port begins reading `out_word` |
| rd_done | input | 1 | One-cycle pulse: serial port finished the read |
| out_word | output | 24 | Stable output word seen by the serial port |
| rdy_n | output | 1 | Active-low data-ready flag |

## Verification
Corrupted buffer-full or read-active state shows up at the ports within a single cycle. Either `out_word` changes in the middle of a read, or a stale or discarded word appears on the edge after `rd_done`. A timer that is off by one moves the falling edge of `rdy_n` by a cycle after a completed read, so the flag is sampled on every cycle of the high window. A sweep moves the arrival of one result across every cycle offset, from the start of a read to the end of the high window, and checks the word and flag level on each cycle.

// File: rtl/rh_pkg.sv
package rh_pkg;
  // Source feeding the output word register on a given edge
  typedef enum logic [1:0] {
    SRC_KEEP   = 2'd0,
    SRC_INPUT  = 2'd1,
    SRC_BUFFER = 2'd2
  } src_e;
endpackage

// File: rtl/rh_hold_buf.sv
module rh_hold_buf #(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         clr,
  output logic         full,
  output logic [W-1:0] data
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full <= 1'b0;
      data <= '0;
    end else if (wr_en) begin
      full <= 1'b1;
      data <= wr_data;
    end else if (clr) begin
      full <= 1'b0;
    end
  end

  // R4: a full buffer only empties through an explicit clear
  a_r4_hold_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !clr && !wr_en) |=> (full && $stable(data)));

  // R9: reset leaves the buffer empty
  a_r9_reset_empty: assert property (@(posedge clk)
    !rst_n |=> !full);
endmodule

// File: rtl/rh_gap_timer.sv
module rh_gap_timer #(
  parameter int MIN_HIGH = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic expired
);
  generate
    if (MIN_HIGH <= 1) begin : g_trivial
      // a single high cycle needs no counting
      assign expired = 1'b1;
    end else begin : g_count
      localparam int CW = $clog2(MIN_HIGH);
      localparam logic [CW-1:0] LOAD = CW'(MIN_HIGH - 1);
      logic [CW-1:0] cnt;

      always_ff @(posedge clk) begin
        if (!rst_n)            cnt <= '0;
        else if (start)        cnt <= LOAD;
        else if (cnt != '0)    cnt <= cnt - 1'b1;
      end

      assign expired = (cnt == '0);

      // R6: the window cannot be expired directly after it starts
      a_r6_window_open: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !expired);
    end
  endgenerate
endmodule

// File: rtl/rh_flag_ctl.sv
module rh_flag_ctl
  import rh_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic res_valid,
  input  logic rd_start,
  input  logic rd_done,
  input  logic buf_full,
  input  logic expired,
  output src_e src,
  output logic buf_wr,
  output logic buf_clr,
  output logic tmr_start,
  output logic reading,
  output logic rdy_n
);
  logic done_ok, start_ok, protect, load_new, fall, pend;

  always_comb begin
    done_ok   = reading && rd_done;
    start_ok  = !reading && rd_start;
    protect   = (reading && !rd_done) || start_ok;
    src       = SRC_KEEP;
    buf_wr    = 1'b0;
    buf_clr   = 1'b0;
    tmr_start = 1'b0;
    if (done_ok) begin
      buf_clr   = 1'b1;
      tmr_start = 1'b1;
      if (res_valid)     src = SRC_INPUT;
      else if (buf_full) src = SRC_BUFFER;
    end else if (res_valid) begin
      if (protect) buf_wr = 1'b1;
      else         src    = SRC_INPUT;
    end
    load_new = (src != SRC_KEEP);
    fall     = rdy_n && !done_ok && expired && (pend || load_new);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reading <= 1'b0;
      rdy_n   <= 1'b1;
      pend    <= 1'b0;
    end else begin
      if (start_ok)     reading <= 1'b1;
      else if (done_ok) reading <= 1'b0;

      if (done_ok)   rdy_n <= 1'b1;
      else if (fall) rdy_n <= 1'b0;

      if (done_ok)       pend <= load_new;
      else if (fall)     pend <= 1'b0;
      else if (load_new) pend <= rdy_n;
    end
  end

  // R2: flag rises only when an active read closes
  a_r2_rise_on_done: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rdy_n) |-> $past(reading && rd_done));

  // R6: flag falls only once the high window has elapsed
  a_r6_fall_gated: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rdy_n) |-> $past(expired));

  // R3: flag level is frozen during an active read
  a_r3_flag_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (reading && !rd_done) |=> $stable(rdy_n));
endmodule

// File: rtl/result_handoff.sv
module result_handoff
  import rh_pkg::*;
#(
  parameter int W        = 24,
  parameter int MIN_HIGH = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         res_valid,
  input  logic [W-1:0] res_data,
  input  logic         rd_start,
  input  logic         rd_done,
  output logic [W-1:0] out_word,
  output logic         rdy_n
);
  src_e         src;
  logic         buf_wr, buf_clr, buf_full, tmr_start, expired, reading;
  logic [W-1:0] buf_data;

  rh_flag_ctl u_ctl (
    .clk       (clk),
    .rst_n     (rst_n),
    .res_valid (res_valid),
    .rd_start  (rd_start),
    .rd_done   (rd_done),
    .buf_full  (buf_full),
    .expired   (expired),
    .src       (src),
    .buf_wr    (buf_wr),
    .buf_clr   (buf_clr),
    .tmr_start (tmr_start),
    .reading   (reading),
    .rdy_n     (rdy_n)
  );

  rh_hold_buf #(.W(W)) u_buf (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (buf_wr),
    .wr_data (res_data),
    .clr     (buf_clr),
    .full    (buf_full),
    .data    (buf_data)
  );

  rh_gap_timer #(.MIN_HIGH(MIN_HIGH)) u_tmr (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (tmr_start),
    .expired (expired)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) out_word <= '0;
    else begin
      case (src)
        SRC_INPUT:  out_word <= res_data;
        SRC_BUFFER: out_word <= buf_data;
        default:    out_word <= out_word;
      endcase
    end
  end

  // R3: the word under read never changes
  a_r3_no_clobber: assert property (@(posedge clk) disable iff (!rst_n)
    (reading && !rd_done) |=> $stable(out_word));

  // R4: an arrival during a read lands in the buffer
  a_r4_buffered: assert property (@(posedge clk) disable iff (!rst_n)
    (reading && !rd_done && res_valid) |=> (buf_full && buf_data == $past(res_data)));

  // R7: with the flag low and no read, a result is written straight through
  a_r7_overwrite: assert property (@(posedge clk) disable iff (!rst_n)
    (!reading && !rd_start && res_valid && !rdy_n) |=> (out_word == $past(res_data) && !rdy_n));
endmodule

// File: tb/result_handoff_test.sv
module result_handoff_test;
  localparam int W    = 24;
  localparam int HOLD = 3;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         res_valid = 1'b0;
  logic [W-1:0] res_data = '0;
  logic         rd_start = 1'b0;
  logic         rd_done = 1'b0;
  logic [W-1:0] out_word;
  logic         rdy_n;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #4 clk = ~clk;

  result_handoff #(.W(W), .MIN_HIGH(HOLD)) uut (
    .clk (clk), .rst_n (rst_n), .res_valid (res_valid), .res_data (res_data),
    .rd_start (rd_start), .rd_done (rd_done), .out_word (out_word), .rdy_n (rdy_n)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      errors++;
      $display("FAIL watchdog: run hung, got cycle %0d expected under 20000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic drive(input logic v, input logic [W-1:0] d, input logic s, input logic dn);
    res_valid = v; res_data = d; rd_start = s; rd_done = dn;
    @(negedge clk);
    res_valid = 1'b0; rd_start = 1'b0; rd_done = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drive(1'b0, '0, 1'b0, 1'b0);
  endtask

  task automatic check(input string tag, input logic [W-1:0] ew, input logic ef);
    checks++;
    if (out_word !== ew || rdy_n !== ef) begin
      errors++;
      $display("FAIL %s: got word %h flag %b, expected word %h flag %b",
               tag, out_word, rdy_n, ew, ef);
    end
  endtask

  initial begin
    logic [W-1:0] old_w, new_w, exp_w;
    repeat (3) @(negedge clk);
    check("R9 reset", '0, 1'b1);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9 after release", '0, 1'b1);

    drive(1'b1, 24'h00A001, 1'b0, 1'b0); check("R1 first load", 24'h00A001, 1'b0);
    drive(1'b1, 24'h00B002, 1'b0, 1'b0); check("R7 overwrite", 24'h00B002, 1'b0);

    drive(1'b0, '0, 1'b1, 1'b0);          check("R3 read start", 24'h00B002, 1'b0);
    drive(1'b1, 24'h00C003, 1'b0, 1'b0);  check("R3 protected", 24'h00B002, 1'b0);
    drive(1'b1, 24'h00D004, 1'b0, 1'b0);  check("R4 replace", 24'h00B002, 1'b0);
    drive(1'b0, '0, 1'b0, 1'b1);          check("R5 promote", 24'h00D004, 1'b1);
    idle(1); check("R6 window 1", 24'h00D004, 1'b1);
    idle(1); check("R6 window 2", 24'h00D004, 1'b1);
    idle(1); check("R6 window end", 24'h00D004, 1'b0);

    drive(1'b0, '0, 1'b0, 1'b1);          check("R2 stray done", 24'h00D004, 1'b0);

    drive(1'b0, '0, 1'b1, 1'b0);
    drive(1'b0, '0, 1'b0, 1'b1);          check("R8 empty done", 24'h00D004, 1'b1);
    idle(8);                              check("R8 stays high", 24'h00D004, 1'b1);
    drive(1'b1, 24'h00E005, 1'b0, 1'b0);  check("R1 load after wait", 24'h00E005, 1'b0);

    drive(1'b0, '0, 1'b1, 1'b0);
    drive(1'b0, '0, 1'b0, 1'b1);          check("R6 done", 24'h00E005, 1'b1);
    drive(1'b1, 24'h00F006, 1'b0, 1'b0);  check("R6 load in window", 24'h00F006, 1'b1);
    idle(1); check("R6 still high", 24'h00F006, 1'b1);
    idle(1); check("R6 falls", 24'h00F006, 1'b0);

    drive(1'b0, '0, 1'b1, 1'b0);
    drive(1'b1, 24'h0A0007, 1'b0, 1'b0);
    drive(1'b1, 24'h0B0008, 1'b0, 1'b1);  check("R5 newest at done", 24'h0B0008, 1'b1);
    idle(3);                              check("R5 after window", 24'h0B0008, 1'b0);
    drive(1'b0, '0, 1'b1, 1'b0);
    drive(1'b0, '0, 1'b0, 1'b1);          check("R4 discarded not delivered", 24'h0B0008, 1'b1);
    idle(4);                              check("R4 still discarded", 24'h0B0008, 1'b1);

    // Sweep: one result at every offset across a 3-cycle read and the window
    for (int off = 0; off <= 6; off++) begin
      for (int rep = 0; rep < 3; rep++) begin
        old_w = W'(24'h100000 * (off + 1) + rep * 16 + 1);
        new_w = W'(24'h200000 + 24'h1000 * off + rep * 16 + 2);
        drive(1'b1, old_w, 1'b0, 1'b0);
        check("R1 sweep base", old_w, 1'b0);
        for (int t = 0; t <= 6; t++) begin
          drive(t == off, new_w, t == 0, t == 3);
          if (t < 3)        exp_w = old_w;
          else if (off <= 3) exp_w = new_w;
          else              exp_w = (t >= off) ? new_w : old_w;
          if (off == 0 && t == 0) check("R10 sweep", exp_w, 1'b0);
          else check("R6 sweep", exp_w, (t >= 3 && t < 6) ? 1'b1 : 1'b0);
        end
        idle(2);
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule